// File: doc/BRIEF.md
# Ordered Power-Down Clock Sequencer

This block sits between a clock synthesizer's free-running clock sources and the output pins. It takes an asynchronous, active-low power-down request and takes the output clocks down in a fixed order. The fixed-frequency bus clock goes first, then the 66 MHz buffer clock, then the remaining clocks as one group. Each clock is gated so that it stops low on its own falling edge and never produces a shortened pulse. The differential CPU pair is parked rather than stopped: the true output is held high and the complement output has its driver disabled. Once every clock has stopped, a core-off flag tells the rest of the generator that it may shut down.

All sequencing runs in the complement CPU clock domain. The request is synchronized there and must be seen low on two consecutive rising edges before anything happens. Each stage waits for a stopped or running status that its gate returns through a synchronizer. When the request is released, the core-off flag clears first. A programmable wait then stands in for the PLL lock time. After that the clocks restart in reverse order, each on a rising edge.

Top module: `pds_seq`

## Requirements
- R1: `pd_ni` is synchronized into the `cpu_c_clk_i` domain and starts a shutdown only when it is sampled low on two consecutive rising edges of `cpu_c_clk_i`. A low pulse that is sampled only once is ignored: no clock stops and `core_off_o` stays 0.
- R2: In a shutdown, `bus_clk_o` stops first, and it stops low on a falling edge of `bus_clk_i`.
- R3: `buf_clk_o` is disabled only after `bus_clk_o` has been reported stopped. Its last falling edge comes after the last falling edge of `bus_clk_o`.
- R4: `cpu_c_o` and every bit of `oth_clk_o` are disabled only after `buf_clk_o` has been reported stopped. Each one has its last falling edge after the last falling edge of `buf_clk_o`, and each stops low.
- R5: During shutdown, `cpu_t_o` is parked high: it stops on a rising edge that comes after `buf_clk_o` has stopped. `cpu_c_oe_o` is 0 (complement driver off) only while every group clock is stopped.
- R6: `core_off_o` rises only after every output clock has stopped. While it is 1, no output clock changes and all gated outputs except `cpu_t_o` are low.
- R7: No output clock has a high or low phase shorter than half the period of its source clock, whether running, stopping or restarting.
- R8: When `pd_ni` returns high, `core_off_o` clears first. At least `LOCK_CYC` cycles of `cpu_c_clk_i` later the group clocks restart, then `buf_clk_o`, then `bus_clk_o`. Each restarts on a rising edge, and `cpu_c_oe_o` is 1 again before `bus_clk_o` restarts.
- R9: A sequence already under way always runs to its end. A request that arrives during wake-up is acted on only after all clocks are running again. A release during shutdown lets the shutdown finish (one `core_off_o` cycle) before the wake-up begins.
- R10: During and just after reset, all clocks pass through ungated, `cpu_c_oe_o` is 1 and `core_off_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cpu_c_clk_i | input | 1 | Complement CPU source clock, also the sequencer clock |
| cpu_t_clk_i | input | 1 | True CPU source clock |
| bus_clk_i | input | 1 | Fixed-frequency bus source clock |
| buf_clk_i | input | 1 | 66 MHz buffer source clock |
| oth_clk_i | input | N_OTH | Remaining source clocks |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pd_ni | input | 1 | Asynchronous active-low power-down request |
| cpu_c_o | output | 1 | Gated complement CPU clock |
| cpu_t_o | output | 1 | Gated true CPU clock, parked high in power-down |
| cpu_c_oe_o | output | 1 | Output enable for the complement CPU driver |
| bus_clk_o | output | 1 | Gated bus clock |
| buf_clk_o | output | 1 | Gated buffer clock |
| oth_clk_o | output | N_OTH | Gated remaining clocks |
| core_off_o | output | 1 | Generator core may be powered off |

## Verification
A change of the request can land in the same cycle as another step of the sequencer, either a restart step or a stop step. The bench provokes the first case by re-asserting the request while the lock wait or a restart stage is still running. It provokes the second by releasing the request a few cycles into a shutdown. Randomly timed low and high phases of the request produce many more such overlaps. Every event is judged by edge monitors on the outputs: stop order against last falling edges, restart order against first rising edges after `core_off_o` falls, and minimum phase widths on every edge. Each long request must end with `core_off_o` high, and each long release must end with all clocks running.

// File: rtl/pds_pkg.sv
`timescale 1ns/1ps
package pds_pkg;
  typedef enum logic [3:0] {
    ST_RUN,
    ST_STOP_BUS,
    ST_STOP_BUF,
    ST_STOP_GRP,
    ST_OFF,
    ST_LOCK,
    ST_WAKE_GRP,
    ST_WAKE_BUF,
    ST_WAKE_BUS
  } pds_state_e;
endpackage

// File: rtl/pds_sync.sv
`timescale 1ns/1ps
module pds_sync #(
  parameter int unsigned   W       = 1,
  parameter logic [W-1:0]  RST_VAL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/pds_gate.sv
`timescale 1ns/1ps
module pds_gate #(
  parameter bit PARK_HIGH = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic clk_o,
  output logic live_o
);
  logic run_s;

  pds_sync #(.W(1), .RST_VAL(1'b1)) u_run_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (run_i),
    .q_o   (run_s)
  );

  if (PARK_HIGH) begin : g_park_high
    // park/unpark on the rising edge: output is already high there
    logic park_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) park_q <= 1'b0;
      else         park_q <= ~run_s;
    end
    assign clk_o  = clk_i | park_q;
    assign live_o = ~park_q;
  end else begin : g_stop_low
    // enable changes only while the source is low
    logic en_q;
    always_ff @(negedge clk_i or negedge rst_ni) begin
      if (!rst_ni) en_q <= 1'b1;
      else         en_q <= run_s;
    end
    assign clk_o  = clk_i & en_q;
    assign live_o = en_q;
  end
endmodule

// File: rtl/pds_fsm.sv
`timescale 1ns/1ps
module pds_fsm
  import pds_pkg::*;
#(
  parameter int unsigned LOCK_CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pd_s_i,
  input  logic pd_p_i,
  input  logic ack_bus_i,
  input  logic ack_buf_i,
  input  logic grp_any_i,
  input  logic grp_all_i,
  output logic en_bus_o,
  output logic en_buf_o,
  output logic en_grp_o,
  output logic oe_o,
  output logic off_o
);
  localparam int unsigned CW = (LOCK_CYC > 1) ? $clog2(LOCK_CYC) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(LOCK_CYC - 1);

  pds_state_e state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_RUN:      if (!pd_s_i && !pd_p_i) state_d = ST_STOP_BUS;
      ST_STOP_BUS: if (!ack_bus_i)         state_d = ST_STOP_BUF;
      ST_STOP_BUF: if (!ack_buf_i)         state_d = ST_STOP_GRP;
      ST_STOP_GRP: if (!grp_any_i)         state_d = ST_OFF;
      ST_OFF: begin
        cnt_d = '0;
        if (pd_s_i) state_d = ST_LOCK;
      end
      ST_LOCK: begin
        if (cnt_q == CNT_LAST) state_d = ST_WAKE_GRP;
        else                   cnt_d   = cnt_q + 1'b1;
      end
      ST_WAKE_GRP: if (grp_all_i) state_d = ST_WAKE_BUF;
      ST_WAKE_BUF: if (ack_buf_i) state_d = ST_WAKE_BUS;
      ST_WAKE_BUS: if (ack_bus_i) state_d = ST_RUN;
      default:     state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RUN;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign en_bus_o = (state_q == ST_RUN) || (state_q == ST_WAKE_BUS);
  assign en_buf_o = (state_q == ST_RUN) || (state_q == ST_STOP_BUS) ||
                    (state_q == ST_WAKE_BUF) || (state_q == ST_WAKE_BUS);
  assign en_grp_o = (state_q == ST_RUN) || (state_q == ST_STOP_BUS) ||
                    (state_q == ST_STOP_BUF) || (state_q == ST_WAKE_GRP) ||
                    (state_q == ST_WAKE_BUF) || (state_q == ST_WAKE_BUS);
  assign oe_o     = (state_q != ST_OFF) && (state_q != ST_LOCK);
  assign off_o    = (state_q == ST_OFF);
endmodule

// File: rtl/pds_seq.sv
`timescale 1ns/1ps
module pds_seq #(
  parameter int unsigned N_OTH    = 3,
  parameter int unsigned LOCK_CYC = 16
) (
  input  logic             cpu_c_clk_i,
  input  logic             cpu_t_clk_i,
  input  logic             bus_clk_i,
  input  logic             buf_clk_i,
  input  logic [N_OTH-1:0] oth_clk_i,
  input  logic             rst_ni,
  input  logic             pd_ni,
  output logic             cpu_c_o,
  output logic             cpu_t_o,
  output logic             cpu_c_oe_o,
  output logic             bus_clk_o,
  output logic             buf_clk_o,
  output logic [N_OTH-1:0] oth_clk_o,
  output logic             core_off_o
);
  // group: others, then cpu_c, then cpu_t (parked high) at the top
  localparam int unsigned G  = N_OTH + 2;
  localparam int unsigned AW = G + 2;

  logic pd_s, pd_p;
  logic en_bus, en_buf, en_grp, oe;
  logic live_bus, live_buf, ack_bus, ack_buf;
  logic [G-1:0] g_src, g_out, g_live, g_ack;
  logic grp_any, grp_all;

  pds_sync #(.W(1), .RST_VAL(1'b1)) u_pd_sync (
    .clk_i (cpu_c_clk_i),
    .rst_ni(rst_ni),
    .d_i   (pd_ni),
    .q_o   (pd_s)
  );

  always_ff @(posedge cpu_c_clk_i or negedge rst_ni) begin
    if (!rst_ni) pd_p <= 1'b1;
    else         pd_p <= pd_s;
  end

  pds_fsm #(.LOCK_CYC(LOCK_CYC)) u_fsm (
    .clk_i    (cpu_c_clk_i),
    .rst_ni   (rst_ni),
    .pd_s_i   (pd_s),
    .pd_p_i   (pd_p),
    .ack_bus_i(ack_bus),
    .ack_buf_i(ack_buf),
    .grp_any_i(grp_any),
    .grp_all_i(grp_all),
    .en_bus_o (en_bus),
    .en_buf_o (en_buf),
    .en_grp_o (en_grp),
    .oe_o     (oe),
    .off_o    (core_off_o)
  );

  pds_gate #(.PARK_HIGH(1'b0)) u_gate_bus (
    .clk_i (bus_clk_i),
    .rst_ni(rst_ni),
    .run_i (en_bus),
    .clk_o (bus_clk_o),
    .live_o(live_bus)
  );

  pds_gate #(.PARK_HIGH(1'b0)) u_gate_buf (
    .clk_i (buf_clk_i),
    .rst_ni(rst_ni),
    .run_i (en_buf),
    .clk_o (buf_clk_o),
    .live_o(live_buf)
  );

  assign g_src = {cpu_t_clk_i, cpu_c_clk_i, oth_clk_i};

  for (genvar gi = 0; gi < G; gi++) begin : g_grp
    pds_gate #(.PARK_HIGH(gi == G - 1)) u_gate (
      .clk_i (g_src[gi]),
      .rst_ni(rst_ni),
      .run_i (en_grp),
      .clk_o (g_out[gi]),
      .live_o(g_live[gi])
    );
  end

  pds_sync #(.W(AW), .RST_VAL({AW{1'b1}})) u_ack_sync (
    .clk_i (cpu_c_clk_i),
    .rst_ni(rst_ni),
    .d_i   ({g_live, live_buf, live_bus}),
    .q_o   ({g_ack, ack_buf, ack_bus})
  );

  assign grp_any    = |g_ack;
  assign grp_all    = &g_ack;
  assign oth_clk_o  = g_out[N_OTH-1:0];
  assign cpu_c_o    = g_out[N_OTH];
  assign cpu_t_o    = g_out[G-1];
  assign cpu_c_oe_o = oe;
endmodule

// File: rtl/pds_seq_chk.sv
`timescale 1ns/1ps
module pds_seq_chk #(
  parameter int unsigned LOCK_CYC = 16
) (
  input logic clk_i,
  input logic rst_ni,
  input logic pd_s,
  input logic pd_p,
  input logic en_bus,
  input logic en_buf,
  input logic en_grp,
  input logic ack_bus,
  input logic ack_buf,
  input logic grp_any,
  input logic grp_all,
  input logic core_off,
  input logic oe
);
  localparam int unsigned CW = $clog2(LOCK_CYC + 1);
  localparam logic [CW-1:0] CMAX = CW'(LOCK_CYC);

  // cycles since core_off last seen high, saturating
  logic [CW-1:0] low_cnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        low_cnt <= '0;
    else if (core_off)  low_cnt <= '0;
    else if (low_cnt != CMAX) low_cnt <= low_cnt + 1'b1;
  end

  AST_START_TWO_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(en_bus) |-> (!$past(pd_s) && !$past(pd_p)));                 // R1
  AST_BUF_AFTER_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_buf |-> !ack_bus);                                             // R3
  AST_GRP_AFTER_BUF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_grp |-> !ack_buf);                                             // R4
  AST_OE_ONLY_PARKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe |-> !grp_any);                                                 // R5
  AST_OFF_ALL_STOPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_off |-> (!ack_bus && !ack_buf && !grp_any));                  // R6
  AST_LOCK_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(en_grp) |-> (low_cnt >= CMAX));                              // R8
  AST_BUS_LAST_WAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(en_bus) |-> (ack_buf && grp_all));                           // R8
endmodule

bind pds_seq pds_seq_chk #(.LOCK_CYC(LOCK_CYC)) u_chk (
  .clk_i   (cpu_c_clk_i),
  .rst_ni  (rst_ni),
  .pd_s    (pd_s),
  .pd_p    (pd_p),
  .en_bus  (en_bus),
  .en_buf  (en_buf),
  .en_grp  (en_grp),
  .ack_bus (ack_bus),
  .ack_buf (ack_buf),
  .grp_any (grp_any),
  .grp_all (grp_all),
  .core_off(core_off_o),
  .oe      (oe)
);

// File: tb/pds_seq_test.sv
`timescale 1ns/1ps
module pds_seq_test;
  localparam int N_OTH = 3;
  localparam int LOCK  = 16;
  localparam int NCH   = N_OTH + 3;  // 0 bus, 1 buf, 2 cpu_c, 3.. others
  localparam real TCYC = 20.0;

  logic cpu_c_clk = 1'b0, cpu_t_clk, bus_clk = 1'b0, buf_clk = 1'b0;
  logic [N_OTH-1:0] oth_clk;
  logic rst_ni = 1'b0, pd_ni = 1'b1;
  logic cpu_c_o, cpu_t_o, cpu_c_oe_o, bus_clk_o, buf_clk_o, core_off_o;
  logic [N_OTH-1:0] oth_clk_o;

  int n_chk = 0, n_err = 0;

  always #10 cpu_c_clk = ~cpu_c_clk;   // 50 MHz
  assign cpu_t_clk = ~cpu_c_clk;
  always #15 bus_clk = ~bus_clk;
  always #8  buf_clk = ~buf_clk;
  for (genvar i = 0; i < N_OTH; i++) begin : g_src
    logic c = 1'b0;
    always #(6.0 + 3.0 * i) c = ~c;
    assign oth_clk[i] = c;
  end

  pds_seq #(.N_OTH(N_OTH), .LOCK_CYC(LOCK)) uut (
    .cpu_c_clk_i(cpu_c_clk), .cpu_t_clk_i(cpu_t_clk),
    .bus_clk_i(bus_clk), .buf_clk_i(buf_clk), .oth_clk_i(oth_clk),
    .rst_ni(rst_ni), .pd_ni(pd_ni),
    .cpu_c_o(cpu_c_o), .cpu_t_o(cpu_t_o), .cpu_c_oe_o(cpu_c_oe_o),
    .bus_clk_o(bus_clk_o), .buf_clk_o(buf_clk_o), .oth_clk_o(oth_clk_o),
    .core_off_o(core_off_o)
  );

  task automatic check(input bit ok, input string req, input string msg);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: %s", req, msg);
    end
  endtask

  function automatic real half_p(input int ch);
    case (ch)
      0:       return 15.0;
      1:       return 8.0;
      2:       return 10.0;
      default: return 6.0 + 3.0 * (ch - 3);
    endcase
  endfunction

  // ---------------- output monitors ----------------
  logic [NCH-1:0] mon_o;
  assign mon_o = {oth_clk_o, cpu_c_o, buf_clk_o, bus_clk_o};

  real tfall [NCH];
  real trise [NCH];
  real first_r [NCH];
  real t_wake, t_park, first_t_fall;
  bit  mon_on = 1'b0, waking = 1'b0;
  int  n_off_rise = 0, cnt_bus_i = 0, cnt_bus_o = 0;

  always @(posedge bus_clk)   cnt_bus_i++;
  always @(posedge bus_clk_o) cnt_bus_o++;

  for (genvar i = 0; i < NCH; i++) begin : g_mon
    always @(posedge mon_o[i]) begin
      if (mon_on) begin
        check($realtime - tfall[i] >= half_p(i) - 0.01, "R7",
              $sformatf("ch%0d low phase %0.2f exp >= %0.2f", i, $realtime - tfall[i], half_p(i)));
        check(!core_off_o, "R6", $sformatf("ch%0d rose while core_off=%0b exp 0", i, core_off_o));
        if (waking && first_r[i] == 0.0) first_r[i] = $realtime;
      end
      trise[i] = $realtime;
    end
    always @(negedge mon_o[i]) begin
      if (mon_on) begin
        check($realtime - trise[i] >= half_p(i) - 0.01, "R7",
              $sformatf("ch%0d high phase %0.2f exp >= %0.2f", i, $realtime - trise[i], half_p(i)));
        check(!core_off_o, "R6", $sformatf("ch%0d fell while core_off=%0b exp 0", i, core_off_o));
      end
      tfall[i] = $realtime;
    end
  end

  real t_rise_t = 0.0, t_fall_t = 0.0;
  always @(posedge cpu_t_o) begin
    if (mon_on) check($realtime - t_fall_t >= 9.99, "R7",
                      $sformatf("cpu_t low phase %0.2f exp >= 10", $realtime - t_fall_t));
    t_rise_t = $realtime;
  end
  always @(negedge cpu_t_o) begin
    if (mon_on) begin
      check($realtime - t_rise_t >= 9.99, "R7",
            $sformatf("cpu_t high phase %0.2f exp >= 10", $realtime - t_rise_t));
      check(!core_off_o, "R5", "cpu_t_o left its parked level while core_off=1");
    end
    if (waking && first_t_fall == 0.0) first_t_fall = $realtime;
    t_fall_t = $realtime;
  end

  function automatic bit group_after(input real t_ref);
    for (int k = 2; k < NCH; k++) if (!(tfall[k] > t_ref)) return 1'b0;
    return 1'b1;
  endfunction

  // stop ordering, judged at core-off
  always @(posedge core_off_o) begin
    #1;
    n_off_rise++;
    if (mon_on) begin
      check(tfall[0] < tfall[1], "R3",
            $sformatf("buf last fall %0.2f exp after bus last fall %0.2f", tfall[1], tfall[0]));
      check(group_after(tfall[1]), "R4", "a group clock stopped before buf_clk_o");
      check(mon_o == '0, "R2", $sformatf("outputs %b exp all low at core-off", mon_o));
      check(cpu_t_o && t_rise_t > tfall[1], "R5",
            $sformatf("cpu_t_o=%0b rise %0.2f exp 1 and after %0.2f", cpu_t_o, t_rise_t, tfall[1]));
      check(!cpu_c_oe_o, "R5", $sformatf("cpu_c_oe_o=%0b exp 0", cpu_c_oe_o));
    end
  end

  always @(negedge core_off_o) begin
    if (mon_on) begin
      waking = 1'b1;
      t_wake = $realtime;
      first_t_fall = 0.0;
      for (int k = 0; k < NCH; k++) first_r[k] = 0.0;
    end
  end

  function automatic bit wake_order_ok(input real t_bus);
    real gmin = 1.0e18;
    for (int k = 2; k < NCH; k++) begin
      if (first_r[k] == 0.0 || !(first_r[k] < first_r[1])) return 1'b0;
      if (first_r[k] < gmin) gmin = first_r[k];
    end
    if (first_r[1] == 0.0 || !(first_r[1] < t_bus)) return 1'b0;
    if (first_t_fall == 0.0) return 1'b0;
    return (gmin - t_wake) >= LOCK * TCYC;
  endfunction

  always @(posedge bus_clk_o) begin
    if (waking) begin
      #0;
      check(wake_order_ok($realtime), "R8",
            $sformatf("wake order: grp0 %0.2f buf %0.2f bus %0.2f off-clear %0.2f",
                      first_r[2], first_r[1], $realtime, t_wake));
      check(cpu_c_oe_o, "R8", $sformatf("cpu_c_oe_o=%0b exp 1 at bus restart", cpu_c_oe_o));
      waking = 1'b0;
    end
  end

  // ---------------- stimulus ----------------
  task automatic cyc(input int n);
    repeat (n) @(posedge cpu_c_clk);
    #5;
  endtask

  function automatic bit exp_off(input int low_cycles);
    return low_cycles >= 120;  // long enough to finish any pending wake plus a full stop
  endfunction

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    #(150000 * 20);
    check(1'b0, "R9", "watchdog expired, actual running exp finished");
    finish_run();
  end

  initial begin
    int base_off, d0, d1, lo, hi;
    void'($urandom(32'd4711));
    #45;
    // R10: reset state
    check(!core_off_o, "R10", $sformatf("core_off_o=%0b exp 0 in reset", core_off_o));
    check(cpu_c_oe_o, "R10", $sformatf("cpu_c_oe_o=%0b exp 1 in reset", cpu_c_oe_o));
    check(cpu_t_o == cpu_t_clk, "R10", $sformatf("cpu_t_o=%0b exp %0b", cpu_t_o, cpu_t_clk));
    rst_ni = 1'b1;
    cyc(10);
    mon_on = 1'b1;
    d0 = cnt_bus_i - cnt_bus_o;
    cyc(20);
    check(cnt_bus_i - cnt_bus_o == d0, "R10", "bus clock did not pass through after reset");

    // R1: one-sample low pulse is ignored
    base_off = n_off_rise;
    d0 = cnt_bus_i - cnt_bus_o;
    @(posedge cpu_c_clk); #16 pd_ni = 1'b0; #8 pd_ni = 1'b1;
    cyc(60);
    d1 = cnt_bus_i - cnt_bus_o;
    check(d1 == d0, "R1", $sformatf("lost bus edges %0d exp 0", d1 - d0));
    check(n_off_rise == base_off && !core_off_o, "R1",
          $sformatf("core-off events %0d exp 0", n_off_rise - base_off));

    // R2..R6: long request
    pd_ni = 1'b0;
    cyc(130);
    check(core_off_o == exp_off(130), "R6", $sformatf("core_off_o=%0b exp %0b", core_off_o, exp_off(130)));
    check(cpu_t_o && !cpu_c_oe_o, "R5", $sformatf("cpu_t_o=%0b oe=%0b exp 1/0", cpu_t_o, cpu_c_oe_o));
    check(mon_o == '0, "R4", $sformatf("outputs %b exp 0", mon_o));
    pd_ni = 1'b1;
    cyc(120);
    check(!core_off_o && cpu_c_oe_o, "R8", $sformatf("off=%0b oe=%0b exp 0/1", core_off_o, cpu_c_oe_o));

    // R1/R9: two-sample pulse starts a full sequence even though released at once
    base_off = n_off_rise;
    @(posedge cpu_c_clk); #16 pd_ni = 1'b0; #28 pd_ni = 1'b1;
    cyc(120);
    check(n_off_rise == base_off + 1, "R1", $sformatf("core-off events %0d exp 1", n_off_rise - base_off));
    check(!core_off_o && !waking, "R9", $sformatf("off=%0b waking=%0b exp 0/0", core_off_o, waking));

    // R9: request re-asserted in the middle of wake-up
    pd_ni = 1'b0; cyc(130);
    pd_ni = 1'b1; cyc(LOCK + 4);
    base_off = n_off_rise;
    pd_ni = 1'b0; cyc(130);
    check(core_off_o && n_off_rise == base_off + 1, "R9",
          $sformatf("off=%0b events %0d exp 1/1", core_off_o, n_off_rise - base_off));
    pd_ni = 1'b1; cyc(120);

    // random request timing
    for (int it = 0; it < 30; it++) begin
      if ($urandom % 4 == 0) begin
        @(posedge cpu_c_clk); #16 pd_ni = 1'b0; #8 pd_ni = 1'b1;
      end else begin
        lo = 120 + int'($urandom % 60);
        pd_ni = 1'b0;
        cyc(lo);
        check(core_off_o == exp_off(lo), "R9", $sformatf("it%0d off=%0b exp %0b", it, core_off_o, exp_off(lo)));
        pd_ni = 1'b1;
      end
      hi = 5 + int'($urandom % 100);
      cyc(hi);
    end
    cyc(150);
    check(!core_off_o && cpu_c_oe_o && !waking, "R8",
          $sformatf("final off=%0b oe=%0b waking=%0b exp 0/1/0", core_off_o, cpu_c_oe_o, waking));
    finish_run();
  end
endmodule